// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vectoring

This block is a programmable periodic interrupt source behind a simple synchronous register port. One register sets the request priority level and the vector number. The other sets an 8-bit period modulus and a single bit that inserts a fixed divide-by-512 prescaler in front of the period counter. A down-counter paced by the clock, or by the prescaled tick, raises an interrupt request at the programmed level each time the period runs out.

The processor answers with an acknowledge cycle that carries a level. When that level matches the programmed one, the block returns its vector in the same cycle and drops the request on the next edge. A request level of zero or a modulus of zero stops interrupt generation. After reset the prescaler bit holds the value of an external mode input, sampled while reset is asserted.

Top module: `pit_top`

## Requirements
- R1: After reset the control word reads 0x000F (level 0, vector 0x0F). The timer word reads 0x0100 when `mode_sel` was 1 during reset and 0x0000 when it was 0.
- R2: The control word holds the request level in bits [10:8] and the vector in bits [7:0]. Bits [15:11] ignore writes and read as zero.
- R3: The timer word holds the prescaler-enable bit at bit 8 and the modulus M in bits [7:0]. Bits [15:9] ignore writes and read as zero.
- R4: With the prescaler off and M nonzero, `irq_level` first turns nonzero exactly M clock edges after the edge that writes the timer word. It expires again every M edges after that.
- R5: With the prescaler on, the first expiry comes exactly 512*M edges after the timer write.
- R6: While the level is 0 or M is 0, `irq_level` stays 0.
- R7: A pending request drives `irq_level` with the programmed level and holds it until a matching acknowledge. An acknowledge with a different level gives `iack_hit`=0 and `iack_vector`=0, and the request stays.
- R8: During an acknowledge whose level equals the pending level, `iack_hit` is 1 and `iack_vector` equals the programmed vector in that same cycle. The request is gone after the next edge, unless a new expiry falls on that edge.
- R9: A timer write restarts the period. Counter and prescaler reload, so the next expiry is counted from that write.
- R10: Either register can be written at any time. `reg_rdata` shows the word picked by `reg_sel` (0 = control, 1 = timer) from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous except the prescaler bit, which loads synchronously |
| mode_sel | input | 1 | Value loaded into the prescaler-enable bit during reset |
| reg_sel | input | 1 | Register select: 0 control, 1 timer |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Requested level, 0 when no request |
| iack_hit | output | 1 | This block answers the current acknowledge |
| iack_vector | output | 8 | Vector returned on a hit, 0 otherwise |

## Verification
The assertions assume that `iack_valid` and `iack_level` are stable for the whole cycle around each edge. They also assume that reset is held for at least one clock edge, so the prescaler bit can load. The stimulus drives every input only at the falling edge and keeps reset low for several edges. It acknowledges only after it has seen a request, using either the level it programmed or a level it knows is different, so every acknowledge falls into one case the properties describe.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W = 16;
  localparam int LVL_W  = 3;
  localparam int VEC_W  = 8;
  localparam int MOD_W  = 8;

  function automatic logic [DATA_W-1:0] ctl_word(input logic [LVL_W-1:0] lvl,
                                                 input logic [VEC_W-1:0] vec);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_W +: LVL_W] = lvl;
    w[VEC_W-1:0] = vec;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] tmr_word(input logic pre,
                                                 input logic [MOD_W-1:0] m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MOD_W] = pre;
    w[MOD_W-1:0] = m;
    return w;
  endfunction

  function automatic logic [MOD_W-1:0] next_count(input logic [MOD_W-1:0] cur,
                                                  input logic [MOD_W-1:0] m);
    return (cur <= 1) ? m : MOD_W'(cur - 1'b1);
  endfunction
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [LVL_W-1:0]  level,
  output logic [VEC_W-1:0]  vector,
  output logic              pre_en,
  output logic [MOD_W-1:0]  modulus,
  output logic              tmr_wr,
  output logic              gen_en
);
  logic ctl_wr;
  assign ctl_wr = reg_wr & ~reg_sel;
  assign tmr_wr = reg_wr &  reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      vector  <= VEC_RST;
      modulus <= '0;
    end else begin
      if (ctl_wr) begin
        level  <= reg_wdata[VEC_W +: LVL_W];
        vector <= reg_wdata[VEC_W-1:0];
      end
      if (tmr_wr) modulus <= reg_wdata[MOD_W-1:0];
    end
  end

  // prescaler bit loads the mode input while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n)      pre_en <= mode_sel;
    else if (tmr_wr) pre_en <= reg_wdata[MOD_W];
  end

  assign gen_en    = (level != '0) && (modulus != '0);
  assign reg_rdata = reg_sel ? tmr_word(pre_en, modulus) : ctl_word(level, vector);
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PRE_LOG2 = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_en,
  input  logic gen_en,
  input  logic restart,
  output logic tick
);
  generate
    if (PRE_LOG2 == 0) begin : g_none
      assign tick = 1'b1;
    end else begin : g_div
      logic [PRE_LOG2-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             pcnt <= '0;
        else if (restart || !gen_en || !pre_en) pcnt <= '0;
        else                                    pcnt <= pcnt + 1'b1;
      end
      assign tick = pre_en ? (&pcnt) : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             tick,
  input  logic             tmr_wr,
  input  logic [MOD_W-1:0] wr_mod,
  input  logic [MOD_W-1:0] modulus,
  output logic             expire
);
  logic [MOD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (tmr_wr) cnt <= wr_mod;
    else if (!gen_en) cnt <= modulus;
    else if (tick)   cnt <= next_count(cnt, modulus);
  end

  assign expire = gen_en & tick & ~tmr_wr & (cnt == MOD_W'(1));
endmodule

// File: rtl/pit_ack.sv
module pit_ack
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             expire,
  input  logic [LVL_W-1:0] level,
  input  logic [VEC_W-1:0] vector,
  input  logic             iack_valid,
  input  logic [LVL_W-1:0] iack_level,
  output logic             pending,
  output logic [LVL_W-1:0] irq_level,
  output logic             iack_hit,
  output logic [VEC_W-1:0] iack_vector
);
  assign iack_hit = iack_valid & pending & (iack_level == level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= gen_en & ((pending & ~iack_hit) | expire);
  end

  assign irq_level   = pending  ? level  : '0;
  assign iack_vector = iack_hit ? vector : '0;
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int               PRE_LOG2 = 9,
  parameter logic [VEC_W-1:0] VEC_RST  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  output logic [LVL_W-1:0]  irq_level,
  output logic              iack_hit,
  output logic [VEC_W-1:0]  iack_vector
);
  logic [LVL_W-1:0] ctl_level;
  logic [VEC_W-1:0] ctl_vector;
  logic             pre_en;
  logic [MOD_W-1:0] tmr_mod;
  logic             tmr_wr;
  logic             gen_en;
  logic             tick;
  logic             expire;
  logic             pending;

  pit_regs #(.VEC_RST(VEC_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .level(ctl_level), .vector(ctl_vector), .pre_en(pre_en), .modulus(tmr_mod),
    .tmr_wr(tmr_wr), .gen_en(gen_en)
  );

  pit_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .gen_en(gen_en),
    .restart(tmr_wr), .tick(tick)
  );

  pit_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .tick(tick), .tmr_wr(tmr_wr),
    .wr_mod(reg_wdata[MOD_W-1:0]), .modulus(tmr_mod), .expire(expire)
  );

  pit_ack u_ack (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .expire(expire),
    .level(ctl_level), .vector(ctl_vector),
    .iack_valid(iack_valid), .iack_level(iack_level),
    .pending(pending), .irq_level(irq_level),
    .iack_hit(iack_hit), .iack_vector(iack_vector)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker
  import pit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [LVL_W-1:0]  ctl_level,
  input logic [VEC_W-1:0]  ctl_vector,
  input logic              gen_en,
  input logic              tick,
  input logic              expire,
  input logic              pending,
  input logic [LVL_W-1:0]  iack_level,
  input logic [LVL_W-1:0]  irq_level,
  input logic              iack_hit,
  input logic [VEC_W-1:0]  iack_vector
);
  p_ctl_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[DATA_W-1:VEC_W+LVL_W] == '0);

  p_tmr_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata[DATA_W-1:MOD_W+1] == '0);

  p_expire_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (tick && gen_en));

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> irq_level == '0);

  p_level_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != '0 |-> irq_level == ctl_level);

  p_request_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && gen_en && !iack_hit) |=> pending);

  p_no_hit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !iack_hit && iack_vector == '0);

  p_vector_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iack_hit |-> (iack_vector == ctl_vector && iack_level == irq_level));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_hit && !expire) |=> !pending);
endmodule

bind pit_top pit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .ctl_level(ctl_level), .ctl_vector(ctl_vector), .gen_en(gen_en),
  .tick(tick), .expire(expire), .pending(pending),
  .iack_level(iack_level), .irq_level(irq_level),
  .iack_hit(iack_hit), .iack_vector(iack_vector)
);

// File: tb/test_pit_top.sv
module test_pit_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_WAIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [2:0]  irq_level;
  logic        iack_hit;
  logic [7:0]  iack_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_top i_pit_top (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .iack_valid(iack_valid), .iack_level(iack_level),
    .irq_level(irq_level), .iack_hit(iack_hit), .iack_vector(iack_vector)
  );

  function automatic logic [15:0] exp_ctl(input logic [2:0] l, input logic [7:0] v);
    return {5'd0, l, v};
  endfunction
  function automatic logic [15:0] exp_tmr(input logic p, input logic [7:0] m);
    return {7'd0, p, m};
  endfunction
  function automatic int exp_period(input logic p, input logic [7:0] m);
    return p ? 512 * int'(m) : int'(m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); #1 n++;
    end while (irq_level == 3'd0 && n < MAX_WAIT);
  endtask

  task automatic do_reset(input logic ms);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = ms;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_period(input string tag, input logic [2:0] l, input logic [7:0] v,
                            input logic p, input logic [7:0] m);
    int n;
    wr(1'b0, exp_ctl(l, v));
    wr(1'b1, exp_tmr(p, m));
    wait_irq(n);
    check({tag, " first expiry"}, n, exp_period(p, m));
    check("R7 irq level", irq_level, l);
    @(negedge clk);
    iack_valid = 1'b1; iack_level = l;
    #1;
    check("R8 hit", iack_hit, 1'b1);
    check("R8 vector", iack_vector, v);
    @(posedge clk); #1;
    n = 1;
    if (exp_period(p, m) > 1) check("R8 cleared", irq_level, 3'd0);
    @(negedge clk);
    iack_valid = 1'b0;
    while (irq_level == 3'd0 && n < MAX_WAIT) begin
      @(posedge clk); #1 n++;
    end
    check({tag, " repeat period"}, n, exp_period(p, m));
    wr(1'b0, exp_ctl(3'd0, v));
  endtask

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'h5eed));

    do_reset(1'b1);
    rd(1'b0, d); check("R1 ctl reset", d, 16'h000F);
    rd(1'b1, d); check("R1 tmr reset pre=1", d, 16'h0100);
    do_reset(1'b0);
    rd(1'b1, d); check("R1 tmr reset pre=0", d, 16'h0000);

    wr(1'b0, 16'hFFFF);
    rd(1'b0, d); check("R2 ctl reserved bits", d, 16'h07FF);
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, d); check("R3 tmr reserved bits", d, 16'h01FF);
    wr(1'b1, 16'h0000);

    wr(1'b0, exp_ctl(3'd5, 8'hA6));
    rd(1'b0, d); check("R10 ctl readback", d, exp_ctl(3'd5, 8'hA6));

    // R6: level zero with modulus set
    wr(1'b0, exp_ctl(3'd0, 8'h11));
    wr(1'b1, exp_tmr(1'b0, 8'd5));
    repeat (30) @(posedge clk);
    #1 check("R6 level zero silent", irq_level, 3'd0);
    // R6: modulus zero with level set
    wr(1'b0, exp_ctl(3'd3, 8'h22));
    wr(1'b1, exp_tmr(1'b0, 8'd0));
    repeat (300) @(posedge clk);
    #1 check("R6 modulus zero silent", irq_level, 3'd0);
    wr(1'b0, exp_ctl(3'd0, 8'h22));

    // R4 corners
    run_period("R4 m=1", 3'd7, 8'h40, 1'b0, 8'd1);
    run_period("R4 m=2", 3'd1, 8'h41, 1'b0, 8'd2);
    run_period("R4 m=255", 3'd4, 8'hC3, 1'b0, 8'd255);

    // R5 prescaled
    run_period("R5 m=1", 3'd2, 8'h55, 1'b1, 8'd1);
    run_period("R5 m=2", 3'd6, 8'h66, 1'b1, 8'd2);

    // R7 mismatched ack ignored
    wr(1'b0, exp_ctl(3'd3, 8'h77));
    wr(1'b1, exp_tmr(1'b0, 8'd4));
    wait_irq(n);
    @(negedge clk);
    iack_valid = 1'b1; iack_level = 3'd2;
    #1;
    check("R7 mismatch hit", iack_hit, 1'b0);
    check("R7 mismatch vector", iack_vector, 8'h00);
    @(posedge clk); #1;
    check("R7 request held", irq_level, 3'd3);
    @(negedge clk); iack_valid = 1'b0;
    repeat (10) @(posedge clk);
    #1 check("R7 still held", irq_level, 3'd3);
    wr(1'b0, exp_ctl(3'd0, 8'h77));

    // R9 timer write restarts the period
    wr(1'b0, exp_ctl(3'd2, 8'h99));
    wr(1'b1, exp_tmr(1'b0, 8'd10));
    repeat (6) @(posedge clk);
    wr(1'b1, exp_tmr(1'b0, 8'd10));
    wait_irq(n);
    check("R9 restart", n, 10);
    wr(1'b0, exp_ctl(3'd0, 8'h99));

    // random mix
    for (int i = 0; i < 10; i++) begin
      logic [2:0] l;
      logic [7:0] v, m;
      l = 3'($urandom_range(7, 1));
      v = 8'($urandom);
      m = 8'($urandom_range(24, 1));
      run_period("R4 random", l, v, 1'b0, m);
      rd(1'b1, d); check("R10 tmr readback", d, exp_tmr(1'b0, m));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule